// File: doc/BRIEF.md
# ADC Conversion Sequencer and Timer

This block is the digital controller behind a successive-approximation converter. A bus write either launches a conversion or stops the converter. A launch request crosses a short synchronizer, then the sequencer counts conversion-clock ticks through four phases: warm-up, sampling, bit trials and a settling tail. During the bit trials it presents a trial code to the external comparator, and it keeps each trial bit when the comparator reports high. The finished code goes into a high/low result byte pair, and a completion flag is raised.

The conversion clock is modelled as a one-cycle enable tick in the bus clock domain. Only cycles that carry a tick advance the sequence. The length of a conversion depends on the resolution (8 or 10 bits), the sample length (short or long), and whether it is the first conversion after a launch or a later one in continuous mode. When the alternate clock source is selected, the first conversion also pays a fixed startup delay. Any new control write aborts the conversion in progress and drops the clock and reference enables at once. The earlier result is kept.

The result pair works as an output stream without back-pressure. `res_valid_o` is the flag, and `res_ack_i` (the read of the low byte) consumes it. The sequencer never stalls for a consumer. An unread result is overwritten by the next conversion, and the flag stays set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and after a reset that arrives during a conversion, both result bytes are 0, `res_valid_o` is 0, and `clk_en_o`, `ref_en_o`, `sample_o` and `busy_o` are all 0.
- R2: A write with `wr_go_i`=1 raises `busy_o` on the next cycle. `clk_en_o` and `ref_en_o` stay low for the three bus cycles of synchronization and go high after the third clock edge that follows the write.
- R3: Counting only the cycles where `tick_i` is high, and starting after the synchronization, a single conversion (or the first one of a continuous run) completes on its Nth tick. N is 18 for 8-bit short sampling, 38 for 8-bit long, 21 for 10-bit short and 41 for 10-bit long. At full tick rate, the result appears 3+N clock edges after the write.
- R4: In continuous mode (`wr_cont_i`=1), each later conversion starts with no new write and completes after 16, 36, 19 or 39 ticks (8-bit short, 8-bit long, 10-bit short, 10-bit long).
- R5: With `wr_alt_i`=1, the single or first conversion takes STARTUP_TICKS (default 80) more ticks. Later continuous conversions are not lengthened.
- R6: The trials run from the top bit of the selected resolution down to bit 0. During a trial, `dac_o` shows the bits already kept plus the bit under trial. A trial bit is kept if and only if `cmp_i` is high on its tick. With a comparator that reports high when `dac_o` ≤ the input, the code equals min(input, 2^bits−1).
- R7: The result is right-justified. In 10-bit mode, `res_hi_o[1:0]` holds code bits 9:8, `res_hi_o[7:2]`=0, and `res_lo_o` holds bits 7:0. In 8-bit mode, `res_hi_o`=0 and `res_lo_o` holds the code.
- R8: `res_valid_o` rises on the edge that writes the result. `res_ack_i` high while the flag is set clears it on the next edge. If a completion and an acknowledge fall on the same edge, the flag stays set.
- R9: Any write aborts an ongoing conversion. `clk_en_o` and `ref_en_o` are low in the same cycle that `wr_i` is high. The result bytes and the flag are left unchanged, and a write with `wr_go_i`=0 leaves the block idle.
- R10: Cycles with `tick_i` low do not advance the sequence, so the tick counts of R3–R5 hold at any tick rate.
- R11: In single mode, `busy_o`, `clk_en_o` and `ref_en_o` are low on the cycle after the result is written.
- R12: `sample_o` is high for exactly 4 ticks (short sampling) or 24 ticks (long sampling) in each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Control write strobe; aborts any conversion |
| wr_go_i | input | 1 | With wr_i: 1 launches a conversion, 0 stops |
| wr_cont_i | input | 1 | With wr_i: continuous mode |
| wr_res10_i | input | 1 | With wr_i: 1 selects 10-bit, 0 selects 8-bit |
| wr_long_i | input | 1 | With wr_i: long sampling |
| wr_alt_i | input | 1 | With wr_i: alternate clock source (adds startup delay) |
| tick_i | input | 1 | Conversion-clock enable tick |
| cmp_i | input | 1 | Comparator decision for the present trial code |
| res_ack_i | input | 1 | Read of low result byte; consumes the flag |
| dac_o | output | 10 | Trial code presented to the comparator |
| sample_o | output | 1 | Sampling window active |
| clk_en_o | output | 1 | Internal converter clock enable |
| ref_en_o | output | 1 | Reference enable |
| busy_o | output | 1 | Launch pending or conversion running |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| res_valid_o | output | 1 | Completion flag |

## Verification
A result is due 3 edges after the launching write plus N ticks, or N ticks after the previous completion for later continuous conversions. The bench counts edges and ticks from the write and compares against an expected N built from the per-mode tick table. The enables are checked on the second and third edges after the write. Abort effects are checked in the cycle of the write itself, and then again about 80 cycles later. All outputs are sampled 2 ns after a rising edge, once every register on the path has settled. The result is compared against the arithmetic clip of the modelled input.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Configuration captured by a control write.
  typedef struct packed {
    logic cont;
    logic res10;
    logic lng;
    logic alt;
  } seq_cfg_t;

  // Where a conversion stands within its tick count.
  typedef enum logic [1:0] {
    PH_WARM   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_TAIL   = 2'd3
  } seq_phase_t;

endpackage

// File: rtl/adc_seq_front.sv
module adc_seq_front
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     go_i,
  input  seq_cfg_t cfg_i,
  output seq_cfg_t cfg_o,
  output logic     launch_o,
  output logic     pend_o
);

  logic [SYNC_STAGES-1:0] pend_q, pend_nxt;
  seq_cfg_t               cfg_q;

  // The request walks through the stages; a write reloads the chain.
  if (SYNC_STAGES > 1) begin : g_chain
    assign pend_nxt = wr_i ? {{(SYNC_STAGES-1){1'b0}}, go_i}
                           : {pend_q[SYNC_STAGES-2:0], 1'b0};
  end else begin : g_single
    assign pend_nxt = wr_i ? go_i : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cfg_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (wr_i) cfg_q <= cfg_i;
    end
  end

  assign cfg_o    = cfg_q;
  assign launch_o = pend_q[SYNC_STAGES-1];
  assign pend_o   = |pend_q;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_q) <= 1); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (pend_q[0] == $past(go_i))); // R2

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int RES_HI        = 10,
  parameter int RES_LO        = 8,
  parameter int SHORT_SMP     = 4,
  parameter int LONG_SMP      = 24,
  parameter int WARM          = 2,
  parameter int TAIL_LO       = 4,
  parameter int TAIL_HI       = 5,
  parameter int STARTUP_TICKS = 80,
  localparam int MAXLEN = WARM + STARTUP_TICKS + LONG_SMP + RES_HI + TAIL_HI,
  localparam int CW     = $clog2(MAXLEN + 1),
  localparam int IW     = $clog2(RES_HI)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          launch_i,
  input  logic          tick_i,
  input  seq_cfg_t      cfg_i,
  output logic          run_o,
  output seq_phase_t    phase_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);

  logic          run_q, first_q;
  logic [CW-1:0] tcnt_q;
  logic [CW-1:0] lead, smp_len, trl_len, tail_len, smp_end, trl_end, last;

  // Phase boundaries derived from the captured settings.
  always_comb begin
    lead = '0;
    if (first_q) lead = CW'(WARM) + (cfg_i.alt ? CW'(STARTUP_TICKS) : '0);
    smp_len  = cfg_i.lng   ? CW'(LONG_SMP) : CW'(SHORT_SMP);
    trl_len  = cfg_i.res10 ? CW'(RES_HI)   : CW'(RES_LO);
    tail_len = cfg_i.res10 ? CW'(TAIL_HI)  : CW'(TAIL_LO);
    smp_end  = lead + smp_len;
    trl_end  = smp_end + trl_len;
    last     = trl_end + tail_len - CW'(1);
    if (tcnt_q < lead)         phase_o = PH_WARM;
    else if (tcnt_q < smp_end) phase_o = PH_SAMPLE;
    else if (tcnt_q < trl_end) phase_o = PH_TRIAL;
    else                       phase_o = PH_TAIL;
    idx_o = IW'(tcnt_q - smp_end);
  end

  assign done_o = run_q & tick_i & ~abort_i & (tcnt_q == last);
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (abort_i) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (launch_i) begin
      run_q   <= 1'b1;
      first_q <= 1'b1;
      tcnt_q  <= '0;
    end else if (run_q && tick_i) begin
      if (tcnt_q == last) begin
        tcnt_q  <= '0;
        first_q <= 1'b0;
        run_q   <= cfg_i.cont;
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (tcnt_q <= last)); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !run_q); // R9
  AST_SINGLE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_i.cont) |=> !run_q); // R11
  AST_CONT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cfg_i.cont) |=> (run_q && tcnt_q == '0 && !first_q)); // R4
  AST_IDLE_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i && !abort_i && !launch_i) |=> $stable(tcnt_q)); // R10

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
  import adc_seq_pkg::*;
#(
  parameter int RES_HI = 10,
  parameter int RES_LO = 8,
  parameter int DW     = 8,
  localparam int IW = $clog2(RES_HI),
  localparam int WW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              run_i,
  input  seq_phase_t        phase_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              tick_i,
  input  logic              cmp_i,
  input  logic              done_i,
  input  logic              res10_i,
  input  logic              ack_i,
  output logic [RES_HI-1:0] dac_o,
  output logic [DW-1:0]     hi_o,
  output logic [DW-1:0]     lo_o,
  output logic              valid_o
);

  logic [RES_HI-1:0] sar_q, res_q, tbit;
  logic [IW-1:0]     msb, pos;
  logic              trying, valid_q;
  logic [WW-1:0]     wide;

  assign trying = run_i && (phase_i == PH_TRIAL);
  assign msb    = res10_i ? IW'(RES_HI - 1) : IW'(RES_LO - 1);
  assign pos    = msb - idx_i;

  // One decoder slice per code bit marks the bit under trial.
  for (genvar i = 0; i < RES_HI; i++) begin : g_trial
    assign tbit[i] = trying && (pos == IW'(i));
  end

  assign dac_o = sar_q | tbit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
    end else if (run_i && tick_i) begin
      if (phase_i == PH_SAMPLE)  sar_q <= '0;
      else if (trying && cmp_i)  sar_q <= sar_q | tbit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (done_i) res_q <= sar_q;
      if (done_i)     valid_q <= 1'b1;
      else if (ack_i) valid_q <= 1'b0;
    end
  end

  assign wide    = WW'(res_q);
  assign lo_o    = wide[DW-1:0];
  assign hi_o    = wide[WW-1:DW];
  assign valid_o = valid_q;

  AST_TRIAL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tbit)); // R6
  AST_KEEP_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trying && tick_i && cmp_i) |=> ((sar_q & $past(tbit)) != '0)); // R6
  AST_ABORT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> $stable(res_q)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ack_i && !done_i) |=> !valid_q); // R8
  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> valid_q); // R8
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !res10_i) |=> (hi_o == '0)); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_HI        = 10,
  parameter int RES_LO        = 8,
  parameter int DW            = 8,
  parameter int SYNC_STAGES   = 3,
  parameter int SHORT_SMP     = 4,
  parameter int LONG_SMP      = 24,
  parameter int WARM          = 2,
  parameter int TAIL_LO       = 4,
  parameter int TAIL_HI       = 5,
  parameter int STARTUP_TICKS = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_go_i,
  input  logic              wr_cont_i,
  input  logic              wr_res10_i,
  input  logic              wr_long_i,
  input  logic              wr_alt_i,
  input  logic              tick_i,
  input  logic              cmp_i,
  input  logic              res_ack_i,
  output logic [RES_HI-1:0] dac_o,
  output logic              sample_o,
  output logic              clk_en_o,
  output logic              ref_en_o,
  output logic              busy_o,
  output logic [DW-1:0]     res_hi_o,
  output logic [DW-1:0]     res_lo_o,
  output logic              res_valid_o
);

  localparam int IW = $clog2(RES_HI);

  seq_cfg_t      wr_cfg, cfg;
  seq_phase_t    phase;
  logic [IW-1:0] idx;
  logic          launch, pend, run, done;

  assign wr_cfg = '{cont: wr_cont_i, res10: wr_res10_i, lng: wr_long_i, alt: wr_alt_i};

  adc_seq_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .go_i    (wr_go_i),
    .cfg_i   (wr_cfg),
    .cfg_o   (cfg),
    .launch_o(launch),
    .pend_o  (pend)
  );

  adc_seq_timer #(
    .RES_HI       (RES_HI),
    .RES_LO       (RES_LO),
    .SHORT_SMP    (SHORT_SMP),
    .LONG_SMP     (LONG_SMP),
    .WARM         (WARM),
    .TAIL_LO      (TAIL_LO),
    .TAIL_HI      (TAIL_HI),
    .STARTUP_TICKS(STARTUP_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (wr_i),
    .launch_i(launch),
    .tick_i  (tick_i),
    .cfg_i   (cfg),
    .run_o   (run),
    .phase_o (phase),
    .idx_o   (idx),
    .done_o  (done)
  );

  adc_seq_sar #(
    .RES_HI(RES_HI),
    .RES_LO(RES_LO),
    .DW    (DW)
  ) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(wr_i),
    .run_i  (run),
    .phase_i(phase),
    .idx_i  (idx),
    .tick_i (tick_i),
    .cmp_i  (cmp_i),
    .done_i (done),
    .res10_i(cfg.res10),
    .ack_i  (res_ack_i),
    .dac_o  (dac_o),
    .hi_o   (res_hi_o),
    .lo_o   (res_lo_o),
    .valid_o(res_valid_o)
  );

  // A write cuts the analog enables in its own cycle.
  assign clk_en_o = run & ~wr_i;
  assign ref_en_o = run & ~wr_i;
  assign sample_o = run & (phase == PH_SAMPLE);
  assign busy_o   = run | pend;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sample_o && !clk_en_o && !ref_en_o)); // R1

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr, go, wcont, w10, wlng, walt, tick, cmp, ack;
  logic [9:0] dac;
  logic       sample, clk_en, ref_en, busy, res_valid;
  logic [7:0] res_hi, res_lo;

  int  n_cmp = 0, n_bad = 0, edges = 0, tph = 0, tdiv = 1, vin = 0;
  int  last_lo = 0, last_hi = 0;
  bit  tick_prev = 1'b0;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_go_i(go), .wr_cont_i(wcont),
    .wr_res10_i(w10), .wr_long_i(wlng), .wr_alt_i(walt), .tick_i(tick),
    .cmp_i(cmp), .res_ack_i(ack), .dac_o(dac), .sample_o(sample),
    .clk_en_o(clk_en), .ref_en_o(ref_en), .busy_o(busy),
    .res_hi_o(res_hi), .res_lo_o(res_lo), .res_valid_o(res_valid)
  );

  // Ideal comparator: high when the trial code does not exceed the input.
  assign cmp = (int'(dac) <= vin);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step();
    tick_prev = tick;
    @(posedge clk);
    #2;
    edges++;
    tph++;
    tick = ((tph % tdiv) == 0);
    if (edges > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", edges);
      summary();
      $finish;
    end
  endtask

  function automatic int n_first(bit r10, bit lng, bit alt);
    int n;
    n = r10 ? (lng ? 41 : 21) : (lng ? 38 : 18);
    return n + (alt ? 80 : 0);
  endfunction

  function automatic int n_next(bit r10, bit lng);
    return r10 ? (lng ? 39 : 19) : (lng ? 36 : 16);
  endfunction

  task automatic conv(input bit r10, input bit lng, input bit alt, input bit cont,
                      input int nconv, input int v0, input int vstep);
    int  re, tk, sm, k, nexp, code;
    bit  vprev, pack, first;
    ack = 1'b1; step(); ack = 1'b0;
    chk("R8 flag consumed by ack", res_valid, 0);
    vin = v0;
    wr = 1'b1; go = 1'b1; wcont = cont; w10 = r10; wlng = lng; walt = alt;
    step();
    wr = 1'b0; go = 1'b0;
    chk("R2 busy after launch write", busy, 1);
    re = 0; tk = 0; sm = 0; k = 0; first = 1'b1; vprev = 1'b0; pack = 1'b0;
    while (k < nconv) begin
      ack = pack; pack = 1'b0;
      if (sample && tick) sm++;
      step();
      re++;
      if (tick_prev && (!first || re >= 4)) tk++;
      if (first && re == 2) chk("R2 enables low while synchronizing", clk_en | ref_en, 0);
      if (first && re == 3) chk("R2 enables high after sync", clk_en & ref_en, 1);
      if (res_valid && !vprev) begin
        nexp = first ? n_first(r10, lng, alt) : n_next(r10, lng);
        if (first) chk(alt ? "R5 first conversion ticks with startup" : "R3 first conversion ticks", tk, nexp);
        else       chk(tdiv > 1 ? "R10 later conversion ticks at slow rate" : "R4 later conversion ticks", tk, nexp);
        if (first && tdiv == 1) chk("R3 bus edges from write to result", re, 3 + nexp);
        chk("R12 sampling ticks", sm, lng ? 24 : 4);
        code = (vin > (r10 ? 1023 : 255)) ? (r10 ? 1023 : 255) : vin;
        chk("R6 low result byte", res_lo, code & 255);
        chk("R7 high result byte", res_hi, code >> 8);
        last_lo = code & 255; last_hi = code >> 8;
        k++; tk = 0; sm = 0; first = 1'b0; pack = cont; vin += vstep;
      end
      vprev = res_valid;
      if (re > 3000) begin
        chk("R3 conversion finished", 0, 1);
        break;
      end
    end
    if (!cont) begin
      step();
      chk("R11 idle after single result", busy | clk_en | ref_en, 0);
    end else begin
      wr = 1'b1; go = 1'b0;
      #1;
      chk("R9 enables drop in the write cycle", clk_en | ref_en, 0);
      step();
      wr = 1'b0;
      chk("R9 stop write leaves block idle", busy, 0);
      chk("R9 result kept after stop", res_lo, last_lo);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr = 0; go = 0; wcont = 0; w10 = 0; wlng = 0; walt = 0;
    tick = 1'b1; ack = 1'b0;
    repeat (3) step();
    chk("R1 reset low byte", res_lo, 0);
    chk("R1 reset high byte", res_hi, 0);
    chk("R1 reset flag", res_valid, 0);
    chk("R1 reset enables", clk_en | ref_en | sample | busy, 0);
    rst_n = 1'b1;
    step();

    // Every setting for a single conversion.
    for (int c = 0; c < 8; c++)
      conv(c[2], c[1], c[0], 1'b0, 1, (c * 173 + 40) % 1100, 0);
    // Continuous runs, three conversions each.
    for (int c = 0; c < 4; c++)
      conv(c[1], c[0], 1'b0, 1'b1, 3, c * 211 + 5, 307);
    conv(1'b0, 1'b0, 1'b1, 1'b1, 2, 77, 100);
    // Code extremes.
    conv(1'b1, 1'b0, 1'b0, 1'b0, 1, 0, 0);
    conv(1'b1, 1'b1, 1'b0, 1'b0, 1, 1023, 0);
    conv(1'b0, 1'b0, 1'b0, 1'b0, 1, 255, 0);

    // Slow tick rate.
    tdiv = 3;
    conv(1'b1, 1'b0, 1'b0, 1'b0, 1, 600, 0);
    conv(1'b0, 1'b1, 1'b1, 1'b1, 2, 123, 50);
    tdiv = 1;

    // Abort in the middle of a conversion keeps the old result.
    ack = 1'b1; step(); ack = 1'b0;
    wr = 1'b1; go = 1'b1; wcont = 0; w10 = 1; wlng = 1; walt = 0; vin = 500;
    step();
    wr = 1'b0; go = 1'b0;
    repeat (20) step();
    wr = 1'b1;
    #1;
    chk("R9 abort enables low in write cycle", clk_en | ref_en, 0);
    step();
    wr = 1'b0;
    chk("R9 abort leaves idle", busy, 0);
    repeat (80) step();
    chk("R9 low byte kept after abort", res_lo, last_lo);
    chk("R9 high byte kept after abort", res_hi, last_hi);
    chk("R9 flag kept after abort", res_valid, 0);

    // A fresh launch in the middle of a conversion restarts the timing.
    wr = 1'b1; go = 1'b1; wcont = 0; w10 = 0; wlng = 0; walt = 0; vin = 900;
    step();
    wr = 1'b0; go = 1'b0;
    repeat (10) step();
    conv(1'b1, 1'b0, 1'b0, 1'b0, 1, 321, 0);

    // Reset during a conversion clears the result pair.
    wr = 1'b1; go = 1'b1; wcont = 1; w10 = 1; wlng = 0; walt = 0; vin = 700;
    step();
    wr = 1'b0; go = 1'b0;
    repeat (10) step();
    rst_n = 1'b0;
    step();
    chk("R1 reset mid-run low byte", res_lo, 0);
    chk("R1 reset mid-run high byte", res_hi, 0);
    chk("R1 reset mid-run flag", res_valid, 0);
    chk("R1 reset mid-run enables", busy | clk_en | ref_en, 0);
    rst_n = 1'b1;
    step();

    summary();
    $finish;
  end

endmodule